// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-visible side of an SPI master. A host reaches it through 32-bit word reads and writes on a simple select/write-enable bus. It stores the serial configuration and drives it as plain wires to a separate serial engine: the clock divisor, the clock phase and polarity, the chip-select number, the idle level and mode of the chip selects, and the frame format. It also owns the two byte queues between software and that engine.

Bytes written to the transmit data port enter a transmit queue, and the engine takes them from the head of that queue. Bytes that the engine delivers enter a receive queue, and software pops them by reading the receive data port. A status flag in bit 31 of each data port tells software whether the transmit queue is full or the receive queue is empty. Two threshold registers compare against the queue occupancies to form interrupt-pending bits, and an enable mask gates those bits onto a single interrupt line. The two delay words are kept for software and have no effect. The flash-mapping registers read as zero and take writes without effect.

Top module: `spi_regfront`

## Requirements
- R1: After reset the chip-select idle register reads all ones over its NCS bits (0xF for NCS=4) and every other register reads zero; the transmit data port reads 0x00000000 and the receive data port reads 0x80000000.
- R2: The divisor register at offset 0x00 keeps bits 11:0 of a write, reads back with bits 31:12 zero, and drives cfg_div.
- R3: A write to offset 0x48 queues bits 7:0. Queued bytes appear on tx_byte in write order, one per cycle in which tx_take is high and tx_avail is high. The queue holds 8 bytes, a write to a full queue is dropped, and a read of 0x48 returns bit 31 set exactly when 8 bytes are queued, with all other bits zero.
- R4: Bytes pushed with rx_push are read from offset 0x4C in arrival order as {24'b0, byte}. A read finding the queue empty returns 0x80000000. A push into a full queue of 8 bytes is dropped.
- R5: Offset 0x04 holds phase in bit 0 and polarity in bit 1. Offset 0x40 holds protocol in bits 1:0 (0 single, 1 dual, 2 quad), byte order in bit 2, direction in bit 3 and frame length in bits 19:16. All other bits read zero, and each field drives its cfg_ output.
- R6: Offset 0x10 keeps the chip-select number in its low log2(NCS) bits. Offset 0x14 keeps NCS idle-level bits. Offset 0x18 keeps a 2-bit chip-select mode. Each drives its cfg_ output.
- R7: Offset 0x74 reads pending bit 0 = (transmit occupancy < transmit threshold at 0x50, 3 bits) and bit 1 = (receive occupancy > receive threshold at 0x54, 3 bits). Writes to it are ignored. The enable mask is 2 bits at 0x70, and irq is high exactly when a pending bit and its enable bit are both set.
- R8: A read at any other word-aligned offset, at a misaligned address, or at the flash registers 0x60 and 0x64 returns zero. Writes there leave every register unchanged.
- R9: The delay words at 0x28 and 0x2C store all 32 bits of a write and read them back.
- R10: Only a read of 0x4C that finds data removes an entry. A read of 0x48 leaves the transmit queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_byte | output | DW (8) | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Engine consumes the head byte |
| rx_byte | input | DW (8) | Byte from the engine |
| rx_push | input | 1 | Push rx_byte into the receive queue |
| cfg_div | output | DIVW (12) | Clock divisor |
| cfg_pha | output | 1 | Clock phase |
| cfg_pol | output | 1 | Clock polarity |
| cfg_csid | output | log2(NCS) (2) | Selected chip select |
| cfg_csdef | output | NCS (4) | Chip-select idle levels |
| cfg_csmode | output | 2 | Chip-select mode |
| cfg_proto | output | 2 | Lane protocol |
| cfg_endian | output | 1 | Byte bit order |
| cfg_dir | output | 1 | Direction |
| cfg_len | output | 4 | Frame length |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that the bus drives one access per cycle with sel, we and address stable around the clock edge, and that tx_take is raised only while the engine means to consume. Under those conditions a full transmit queue stays full, and a read that pops lowers the occupancy by exactly one. The stimulus changes every input half a cycle away from the rising edge and drives one bus operation at a time. It pushes the engine side only through the two push and take strobes. The bench sweeps every threshold against every occupancy from 0 to 8, and every word offset in the 256-byte space.

// File: rtl/spi_rf_pkg.sv
`timescale 1ns/1ps
package spi_rf_pkg;
   localparam logic [7:0] OFF_DIV    = 8'h00;
   localparam logic [7:0] OFF_CKMODE = 8'h04;
   localparam logic [7:0] OFF_CSID   = 8'h10;
   localparam logic [7:0] OFF_CSDEF  = 8'h14;
   localparam logic [7:0] OFF_CSMODE = 8'h18;
   localparam logic [7:0] OFF_DLY0   = 8'h28;
   localparam logic [7:0] OFF_DLY1   = 8'h2C;
   localparam logic [7:0] OFF_FMT    = 8'h40;
   localparam logic [7:0] OFF_TXD    = 8'h48;
   localparam logic [7:0] OFF_RXD    = 8'h4C;
   localparam logic [7:0] OFF_TXMARK = 8'h50;
   localparam logic [7:0] OFF_RXMARK = 8'h54;
   localparam logic [7:0] OFF_IE     = 8'h70;
   localparam logic [7:0] OFF_IP     = 8'h74;
   localparam int NSRC = 2;

   typedef struct packed {
      logic [3:0] len;
      logic       dir;
      logic       endian;
      logic [1:0] proto;
   } fmt_t;

   function automatic logic [31:0] fmt_word(fmt_t f);
      return {12'b0, f.len, 12'b0, f.dir, f.endian, f.proto};
   endfunction
endpackage

// File: rtl/spi_rf_fifo.sv
`timescale 1ns/1ps
module spi_rf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr, wnext, rnext;
   logic          do_wr, do_rd;

   assign empty = (cnt == '0);
   assign do_wr = push && (cnt != CW'(DEPTH));
   assign do_rd = pop && !empty;
   assign dout  = mem[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + PW'(1);
         assign rnext = rptr + PW'(1);
      end else begin : g_wrap
         assign wnext = (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
         assign rnext = (rptr == PW'(DEPTH - 1)) ? '0 : rptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wnext;
         if (do_rd) rptr <= rnext;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/spi_rf_csr.sv
`timescale 1ns/1ps
module spi_rf_csr
   import spi_rf_pkg::*;
#(
   parameter int AW   = 8,
   parameter int NCS  = 4,
   parameter int DIVW = 12,
   parameter int MW   = 3,
   localparam int CSW = $clog2(NCS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [AW-1:0]   addr,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   output logic [DIVW-1:0] div,
   output logic            pha,
   output logic            pol,
   output logic [CSW-1:0]  csid,
   output logic [NCS-1:0]  csdef,
   output logic [1:0]      csmode,
   output fmt_t            fmt,
   output logic [MW-1:0]   txmark,
   output logic [MW-1:0]   rxmark,
   output logic [NSRC-1:0] ie
);
   logic [31:0] dly0, dly1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div    <= '0;
         pha    <= 1'b0;
         pol    <= 1'b0;
         csid   <= '0;
         csdef  <= '1;
         csmode <= '0;
         dly0   <= '0;
         dly1   <= '0;
         fmt    <= '0;
         txmark <= '0;
         rxmark <= '0;
         ie     <= '0;
      end else if (wr) begin
         case (addr)
            AW'(OFF_DIV):    div    <= wdata[DIVW-1:0];
            AW'(OFF_CKMODE): {pol, pha} <= wdata[1:0];
            AW'(OFF_CSID):   csid   <= wdata[CSW-1:0];
            AW'(OFF_CSDEF):  csdef  <= wdata[NCS-1:0];
            AW'(OFF_CSMODE): csmode <= wdata[1:0];
            AW'(OFF_DLY0):   dly0   <= wdata;
            AW'(OFF_DLY1):   dly1   <= wdata;
            AW'(OFF_FMT):    fmt    <= '{len: wdata[19:16], dir: wdata[3],
                                         endian: wdata[2], proto: wdata[1:0]};
            AW'(OFF_TXMARK): txmark <= wdata[MW-1:0];
            AW'(OFF_RXMARK): rxmark <= wdata[MW-1:0];
            AW'(OFF_IE):     ie     <= wdata[NSRC-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         AW'(OFF_DIV):    rdata = 32'(div);
         AW'(OFF_CKMODE): rdata = {30'b0, pol, pha};
         AW'(OFF_CSID):   rdata = 32'(csid);
         AW'(OFF_CSDEF):  rdata = 32'(csdef);
         AW'(OFF_CSMODE): rdata = {30'b0, csmode};
         AW'(OFF_DLY0):   rdata = dly0;
         AW'(OFF_DLY1):   rdata = dly1;
         AW'(OFF_FMT):    rdata = fmt_word(fmt);
         AW'(OFF_TXMARK): rdata = 32'(txmark);
         AW'(OFF_RXMARK): rdata = 32'(rxmark);
         AW'(OFF_IE):     rdata = 32'(ie);
         default:         rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_regfront.sv
`timescale 1ns/1ps
module spi_regfront
   import spi_rf_pkg::*;
#(
   parameter int AW    = 8,
   parameter int NCS   = 4,
   parameter int DEPTH = 8,
   parameter int DIVW  = 12,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int MW   = $clog2(DEPTH),
   localparam int CSW  = $clog2(NCS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   output logic [DW-1:0]   tx_byte,
   output logic            tx_avail,
   input  logic            tx_take,
   input  logic [DW-1:0]   rx_byte,
   input  logic            rx_push,
   output logic [DIVW-1:0] cfg_div,
   output logic            cfg_pha,
   output logic            cfg_pol,
   output logic [CSW-1:0]  cfg_csid,
   output logic [NCS-1:0]  cfg_csdef,
   output logic [1:0]      cfg_csmode,
   output logic [1:0]      cfg_proto,
   output logic            cfg_endian,
   output logic            cfg_dir,
   output logic [3:0]      cfg_len,
   output logic            irq
);
   generate
      if (AW < 7 || AW > 16) begin : g_bad_aw
         $error("AW must cover offset 0x74 and stay below 17 bits");
      end
      if (NCS < 2 || NCS > 32) begin : g_bad_ncs
         $error("NCS must be between 2 and 32");
      end
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("DEPTH must be between 2 and 256");
      end
      if (DIVW < 1 || DIVW > 32 || DW < 1 || DW > 31) begin : g_bad_w
         $error("DIVW or DW out of range");
      end
   endgenerate

   logic          rd, wr, hit_txd, hit_rxd, hit_ip;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_empty, rx_empty, tx_full;
   logic [DW-1:0] rx_head;
   logic [31:0]   csr_rdata;
   logic [MW-1:0] txmark, rxmark;
   logic [NSRC-1:0] ie, ip;
   fmt_t          fmt;

   assign rd      = bus_sel && !bus_we;
   assign wr      = bus_sel && bus_we;
   assign hit_txd = (bus_addr == AW'(OFF_TXD));
   assign hit_rxd = (bus_addr == AW'(OFF_RXD));
   assign hit_ip  = (bus_addr == AW'(OFF_IP));

   spi_rf_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr && hit_txd), .din(bus_wdata[DW-1:0]),
      .pop(tx_take), .dout(tx_byte), .cnt(tx_cnt), .empty(tx_empty)
   );

   spi_rf_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_byte),
      .pop(rd && hit_rxd), .dout(rx_head), .cnt(rx_cnt), .empty(rx_empty)
   );

   spi_rf_csr #(.AW(AW), .NCS(NCS), .DIVW(DIVW), .MW(MW)) u_csr (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata),
      .rdata(csr_rdata), .div(cfg_div), .pha(cfg_pha), .pol(cfg_pol),
      .csid(cfg_csid), .csdef(cfg_csdef), .csmode(cfg_csmode), .fmt(fmt),
      .txmark(txmark), .rxmark(rxmark), .ie(ie)
   );

   assign tx_avail   = !tx_empty;
   assign tx_full    = (tx_cnt == CW'(DEPTH));
   assign cfg_proto  = fmt.proto;
   assign cfg_endian = fmt.endian;
   assign cfg_dir    = fmt.dir;
   assign cfg_len    = fmt.len;

   assign ip[0] = (tx_cnt < CW'(txmark));
   assign ip[1] = (rx_cnt > CW'(rxmark));
   assign irq   = |(ip & ie);

   always_comb begin
      if (hit_txd)      bus_rdata = {tx_full, 31'b0};
      else if (hit_rxd) bus_rdata = rx_empty ? 32'h8000_0000 : 32'(rx_head);
      else if (hit_ip)  bus_rdata = 32'(ip);
      else              bus_rdata = csr_rdata;
   end
endmodule

// File: rtl/spi_regfront_chk.sv
`timescale 1ns/1ps
module spi_regfront_chk
   import spi_rf_pkg::*;
#(
   parameter int AW    = 8,
   parameter int NCS   = 4,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int MW   = $clog2(DEPTH)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_sel,
   input logic            bus_we,
   input logic [AW-1:0]   bus_addr,
   input logic [31:0]     bus_rdata,
   input logic            tx_take,
   input logic            rx_push,
   input logic [CW-1:0]   tx_cnt,
   input logic [CW-1:0]   rx_cnt,
   input logic [MW-1:0]   tx_mark,
   input logic [NSRC-1:0] ie,
   input logic            irq,
   input logic [NCS-1:0]  cfg_csdef
);
   logic rd, mapped;
   assign rd = bus_sel && !bus_we;

   always_comb begin
      case (bus_addr)
         AW'(OFF_DIV), AW'(OFF_CKMODE), AW'(OFF_CSID), AW'(OFF_CSDEF),
         AW'(OFF_CSMODE), AW'(OFF_DLY0), AW'(OFF_DLY1), AW'(OFF_FMT),
         AW'(OFF_TXD), AW'(OFF_RXD), AW'(OFF_TXMARK), AW'(OFF_RXMARK),
         AW'(OFF_IE), AW'(OFF_IP): mapped = 1'b1;
         default:                  mapped = 1'b0;
      endcase
   end

   p_csdef_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> cfg_csdef == '1);

   p_div_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == AW'(OFF_DIV)) |-> bus_rdata[31:12] == '0);

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt == CW'(DEPTH) && !tx_take) |=> tx_cnt == CW'(DEPTH));

   p_rx_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == AW'(OFF_RXD) && rx_cnt == '0) |-> bus_rdata == 32'h8000_0000);

   p_tx_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ie[0] && tx_cnt < CW'(tx_mark)) |-> irq);

   p_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ie == '0) |-> !irq);

   p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !mapped) |-> bus_rdata == '0);

   p_rx_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == AW'(OFF_RXD) && rx_cnt != '0 && !rx_push)
      |=> rx_cnt == $past(rx_cnt) - CW'(1));
endmodule

bind spi_regfront spi_regfront_chk #(.AW(AW), .NCS(NCS), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tx_take(tx_take),
   .rx_push(rx_push), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_mark(txmark),
   .ie(ie), .irq(irq), .cfg_csdef(cfg_csdef)
);

// File: tb/sim_spi_regfront.sv
`timescale 1ns/1ps
module sim_spi_regfront;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        tx_avail, tx_take = 1'b0, rx_push = 1'b0;
   logic [11:0] cfg_div;
   logic        cfg_pha, cfg_pol, cfg_endian, cfg_dir, irq;
   logic [1:0]  cfg_csid, cfg_csmode, cfg_proto;
   logic [3:0]  cfg_csdef, cfg_len;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   spi_regfront u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_byte(tx_byte), .tx_avail(tx_avail), .tx_take(tx_take),
      .rx_byte(rx_byte), .rx_push(rx_push), .cfg_div(cfg_div),
      .cfg_pha(cfg_pha), .cfg_pol(cfg_pol), .cfg_csid(cfg_csid),
      .cfg_csdef(cfg_csdef), .cfg_csmode(cfg_csmode), .cfg_proto(cfg_proto),
      .cfg_endian(cfg_endian), .cfg_dir(cfg_dir), .cfg_len(cfg_len), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = b;
      @(posedge clk); #1;
      rx_push = 1'b0;
   endtask

   task automatic drain_tx(input int n_exp, input logic [7:0] base);
      int got = 0;
      forever begin
         @(negedge clk);
         if (!tx_avail) break;
         chk("R3 tx order", 32'(tx_byte), 32'(base + 8'(got)));
         tx_take = 1'b1;
         @(posedge clk); #1;
         tx_take = 1'b0;
         got++;
      end
      chk("R3 tx drained count", 32'(got), 32'(n_exp));
   endtask

   function automatic bit is_mapped(input int a);
      case (a)
         'h00, 'h04, 'h10, 'h14, 'h18, 'h28, 'h2C, 'h40, 'h48, 'h4C,
         'h50, 'h54, 'h70, 'h74: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 cfg_csdef", 32'(cfg_csdef), 32'hF);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 tx_avail", 32'(tx_avail), 0);
      rd_chk("R1 csdef read", 8'h14, 32'hF);
      rd_chk("R1 div read", 8'h00, 0);
      rd_chk("R1 fmt read", 8'h40, 0);
      rd_chk("R1 ip read", 8'h74, 0);
      rd_chk("R1 txd read", 8'h48, 0);
      rd_chk("R1 rxd read", 8'h4C, 32'h8000_0000);

      // R2 divisor sweep
      for (int i = 0; i < 16; i++) begin
         v = 32'(i) * 32'h1357_9BDF + 32'(i);
         wr(8'h00, v);
         rd_chk("R2 div read", 8'h00, v & 32'hFFF);
         chk("R2 cfg_div", 32'(cfg_div), v & 32'hFFF);
      end

      // R5 clock mode, all combinations with junk upper bits
      for (int i = 0; i < 4; i++) begin
         wr(8'h04, 32'hFFFF_FFF0 | 32'(i));
         rd_chk("R5 ckmode read", 8'h04, 32'(i));
         chk("R5 pha", 32'(cfg_pha), 32'(i & 1));
         chk("R5 pol", 32'(cfg_pol), 32'((i >> 1) & 1));
      end

      // R5 frame format sweep
      for (int i = 0; i < 16; i++) begin
         v = {12'hABC, 4'(15 - i), 12'h5A0, 4'(i)};
         wr(8'h40, v);
         rd_chk("R5 fmt read", 8'h40, v & 32'h000F_000F);
         chk("R5 proto", 32'(cfg_proto), 32'(i & 3));
         chk("R5 endian", 32'(cfg_endian), 32'((i >> 2) & 1));
         chk("R5 dir", 32'(cfg_dir), 32'((i >> 3) & 1));
         chk("R5 len", 32'(cfg_len), 32'(15 - i));
      end

      // R6 chip-select registers
      for (int i = 0; i < 8; i++) begin
         wr(8'h10, 32'hFFFF_FF00 | 32'(i));
         rd_chk("R6 csid read", 8'h10, 32'(i & 3));
         chk("R6 cfg_csid", 32'(cfg_csid), 32'(i & 3));
         wr(8'h14, 32'(i * 5 + 16));
         rd_chk("R6 csdef read", 8'h14, 32'((i * 5 + 16) & 15));
         chk("R6 cfg_csdef", 32'(cfg_csdef), 32'((i * 5 + 16) & 15));
         wr(8'h18, 32'(i));
         rd_chk("R6 csmode read", 8'h18, 32'(i & 3));
         chk("R6 cfg_csmode", 32'(cfg_csmode), 32'(i & 3));
      end

      // R9 delay words
      wr(8'h28, 32'hDEAD_BEEF);
      wr(8'h2C, 32'h0123_4567);
      rd_chk("R9 dly0", 8'h28, 32'hDEAD_BEEF);
      rd_chk("R9 dly1", 8'h2C, 32'h0123_4567);

      // R8 unused offsets, flash registers, misaligned writes
      wr(8'h00, 32'h0000_0ABC);
      wr(8'h40, 32'h0007_0009);
      wr(8'h60, 32'h0);
      wr(8'h64, 32'h0);
      rd_chk("R8 flash ctl", 8'h60, 0);
      rd_chk("R8 flash fmt", 8'h64, 0);
      for (int a = 0; a < 256; a += 4) begin
         if (!is_mapped(a)) begin
            wr(8'(a), 32'hFFFF_FFFF);
            rd_chk("R8 unused read", 8'(a), 0);
         end
      end
      wr(8'h41, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      rd_chk("R8 misaligned read", 8'h41, 0);
      rd_chk("R8 div kept", 8'h00, 32'hABC);
      rd_chk("R8 fmt kept", 8'h40, 32'h0007_0009);
      rd_chk("R8 dly0 kept", 8'h28, 32'hDEAD_BEEF);
      rd_chk("R8 csmode kept", 8'h18, 32'h3);
      rd_chk("R8 ie kept", 8'h70, 0);
      chk("R8 tx queue untouched", 32'(tx_avail), 0);

      // R3 / R10 transmit queue fill levels 0..9
      for (int n = 0; n <= 9; n++) begin
         for (int k = 0; k < n; k++) wr(8'h48, 32'hFFFF_FF00 | 32'(n * 16 + k));
         rd_chk("R3 txd full flag", 8'h48, (n >= 8) ? 32'h8000_0000 : 32'h0);
         rd_chk("R10 txd reread", 8'h48, (n >= 8) ? 32'h8000_0000 : 32'h0);
         drain_tx((n > 8) ? 8 : n, 8'(n * 16));
      end

      // R7 transmit threshold against every occupancy
      wr(8'h54, 32'h7);
      wr(8'h70, 32'h1);
      for (int m = 0; m < 8; m++) begin
         wr(8'h50, 32'(m));
         for (int k = 0; k <= 8; k++) begin
            for (int j = 0; j < k; j++) wr(8'h48, 32'(j));
            rd_chk("R7 tx pending", 8'h74, (k < m) ? 32'h1 : 32'h0);
            @(negedge clk);
            chk("R7 tx irq", 32'(irq), (k < m) ? 32'h1 : 32'h0);
            drain_tx(k, 8'h00);
         end
      end
      wr(8'h74, 32'h0);
      rd_chk("R7 ip write ignored", 8'h74, 32'h1);
      wr(8'h70, 32'h0);
      @(negedge clk);
      chk("R7 masked irq", 32'(irq), 0);
      wr(8'h50, 32'h0);

      // R7 / R4 receive threshold against every occupancy
      wr(8'h70, 32'h2);
      for (int m = 0; m < 8; m++) begin
         wr(8'h54, 32'(m));
         for (int k = 0; k <= 8; k++) begin
            for (int j = 0; j < k; j++) push_rx(8'(m * 16 + j));
            rd_chk("R7 rx pending", 8'h74, (k > m) ? 32'h2 : 32'h0);
            @(negedge clk);
            chk("R7 rx irq", 32'(irq), (k > m) ? 32'h1 : 32'h0);
            for (int j = 0; j < k; j++)
               rd_chk("R4 rx byte", 8'h4C, 32'(8'(m * 16 + j)));
            rd_chk("R4 rx empty", 8'h4C, 32'h8000_0000);
         end
      end

      // R4 receive overflow drops
      wr(8'h54, 32'h7);
      for (int j = 0; j < 10; j++) push_rx(8'hA0 + 8'(j));
      rd_chk("R4 rx full pending", 8'h74, 32'h2);
      for (int j = 0; j < 8; j++) rd_chk("R4 rx overflow order", 8'h4C, 32'hA0 + 32'(j));
      rd_chk("R10 rx empty after drain", 8'h4C, 32'h8000_0000);
      rd_chk("R10 rx still empty", 8'h4C, 32'h8000_0000);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule